// File: doc/BRIEF.md
# Per-Resource Ownership Semaphore Array

This block holds one hardware semaphore per shared resource, so that independent software compartments can take exclusive ownership of a peripheral before using it. Every request on the register port carries the 3-bit compartment ID of the requester. A semaphore is taken or dropped by writing a 1 to its lock bit. A free semaphore goes to the writer. A held semaphore is released only when its owner writes, and a write from any other compartment leaves it unchanged. Every change is gated by the resource's configuration word. The filtering and semaphore-mode enables must both be set, and the writer's compartment must appear in the resource's whitelist.

Software confirms a claim by reading the semaphore word back and checking that the lock bit is set and that the owner field holds its own ID. For each resource the block also exports a held flag and the owner ID as plain signals, so that an access filter next to it can admit or reject traffic to that resource. Writes arrive one per cycle. Choosing between simultaneous writers is done upstream.

Top module: `rsem_array`

## Requirements
- R1: Reset clears every lock bit, every owner field and every configuration word to zero.
- R2: A write with data bit 0 = 1 to a free, permitted semaphore sets its lock bit (read bit 0) and records the writer's ID, which reads back in bits 6:4.
- R3: A permitted write with data bit 0 = 1 from the current owner releases the semaphore: the lock bit reads 0 and the owner field reads 0.
- R4: While a semaphore is held, a write from a compartment other than the owner has no effect.
- R5: A semaphore write is ignored unless the resource's configuration has both bit 0 (filter enable) and bit 1 (semaphore mode) set.
- R6: A semaphore write is ignored unless bit 16+ID of the resource's configuration (whitelist in bits 23:16) is set for the writer's ID.
- R7: A semaphore write with data bit 0 = 0 has no effect.
- R8: Resource i has its configuration word at byte address 8*i and its semaphore word at 8*i+4. The configuration word reads back exactly as written. Accesses whose address bits 1:0 are not zero, or whose resource index is NUM_RES or larger, change nothing and read 0.
- R9: Read data and the read-valid flag appear in the cycle after the read request. The flag is low in every other cycle.
- R10: The exported held flag and owner ID of each resource equal its semaphore state, and they update on the clock edge that takes the write.
- R11: A write to one resource leaves every other resource's semaphore unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_cid | input | 3 | Compartment ID of the requester |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| res_held | output | NUM_RES | Per-resource held flag |
| res_owner | output | 3*NUM_RES | Per-resource owner ID, resource i in bits 3i+2:3i |

## Verification
A wrong lock or owner register is visible on res_held and res_owner on the clock edge right after the faulty write, and a read-back shows it one cycle later. The bench therefore checks the exported state of all resources after every write. Across every configuration mode and several whitelists, it sweeps every compartment ID against every resource in repeated rounds, which reaches each claim, release, non-owner and gated case. A reference model in the bench, driven only by the rules above, predicts each outcome. Because the semaphore state persists, an error in one case also shows up in the expected state of every later case.

// File: rtl/rsem_pkg.sv
package rsem_pkg;

    localparam int CID_W    = 3;
    localparam int NUM_CID  = 1 << CID_W;
    localparam int WORD_W   = 32;
    localparam int LOCK_POS = 0;
    localparam int OWN_LSB  = 4;
    localparam int FLT_POS  = 0;
    localparam int SEM_POS  = 1;
    localparam int WL_LSB   = 16;

    typedef logic [CID_W-1:0]  cid_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [NUM_CID-1:0] wlist;
        logic               sem_en;
        logic               flt_en;
    } res_cfg_t;

    typedef struct packed {
        logic held;
        cid_t owner;
    } sem_state_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CFG  = 2'd1,
        ACC_SEM  = 2'd2
    } acc_kind_t;

    function automatic res_cfg_t cfg_fields(input word_t w);
        res_cfg_t c;
        c.wlist  = w[WL_LSB +: NUM_CID];
        c.sem_en = w[SEM_POS];
        c.flt_en = w[FLT_POS];
        return c;
    endfunction

    function automatic word_t sem_word(input sem_state_t s);
        word_t w;
        w = '0;
        w[LOCK_POS]            = s.held;
        w[OWN_LSB +: CID_W]    = s.owner;
        return w;
    endfunction

    function automatic logic may_toggle(input res_cfg_t c, input cid_t id);
        return c.flt_en & c.sem_en & c.wlist[id];
    endfunction

endpackage

// File: rtl/rsem_decode.sv
module rsem_decode
    import rsem_pkg::*;
#(
    parameter int NUM_RES = 16,
    parameter int ADDR_W  = 8
) (
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   hit,
    output acc_kind_t              kind,
    output logic [ADDR_W-4:0]      idx
);
    localparam int IDX_W = ADDR_W - 3;

    logic in_range;
    logic aligned;

    always_comb begin
        idx      = req_addr[ADDR_W-1:3];
        aligned  = (req_addr[1:0] == 2'b00);
        in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_RES));
        hit      = req_valid & aligned & in_range;
        if (!hit)
            kind = ACC_NONE;
        else if (req_addr[2])
            kind = ACC_SEM;
        else
            kind = ACC_CFG;
    end

endmodule

// File: rtl/rsem_cell.sv
module rsem_cell
    import rsem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic       sem_we,
    input  word_t      wdata,
    input  cid_t       cid,
    output word_t      cfg_word,
    output sem_state_t state
);
    res_cfg_t cfg;
    logic     permit;
    logic     request;

    always_comb begin
        cfg     = cfg_fields(cfg_word);
        permit  = may_toggle(cfg, cid);
        request = sem_we & wdata[LOCK_POS];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_word <= '0;
            state    <= '0;
        end else begin
            if (cfg_we)
                cfg_word <= wdata;
            if (request && permit) begin
                if (!state.held) begin
                    state.held  <= 1'b1;
                    state.owner <= cid;
                end else if (state.owner == cid) begin
                    state.held  <= 1'b0;
                    state.owner <= '0;
                end
            end
        end
    end

    assert_claim_free_R2: assert property (@(posedge clk) disable iff (rst)
        (request && permit && !state.held) |=> (state.held && state.owner == $past(cid)));

    assert_owner_release_R3: assert property (@(posedge clk) disable iff (rst)
        (request && permit && state.held && state.owner == cid) |=> (!state.held && state.owner == '0));

    assert_foreign_noeffect_R4: assert property (@(posedge clk) disable iff (rst)
        (sem_we && state.held && state.owner != cid) |=> ($stable(state.held) && $stable(state.owner)));

    assert_gated_noeffect_R5: assert property (@(posedge clk) disable iff (rst)
        (sem_we && !(cfg.flt_en && cfg.sem_en)) |=> ($stable(state.held) && $stable(state.owner)));

    assert_wlist_noeffect_R6: assert property (@(posedge clk) disable iff (rst)
        (sem_we && !cfg.wlist[cid]) |=> ($stable(state.held) && $stable(state.owner)));

    assert_zero_write_R7: assert property (@(posedge clk) disable iff (rst)
        (sem_we && !wdata[LOCK_POS]) |=> ($stable(state.held) && $stable(state.owner)));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (!sem_we) |=> ($stable(state.held) && $stable(state.owner)));

    assert_free_owner_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!state.held) |-> (state.owner == '0));

endmodule

// File: rtl/rsem_readmux.sv
module rsem_readmux
    import rsem_pkg::*;
#(
    parameter int NUM_RES = 16,
    parameter int IDX_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_req,
    input  acc_kind_t                kind,
    input  logic [IDX_W-1:0]         idx,
    input  word_t      [NUM_RES-1:0] cfg_all,
    input  sem_state_t [NUM_RES-1:0] sem_all,
    output word_t                    rd_data,
    output logic                     rd_valid
);
    word_t sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_RES; i++) begin
            if (idx == IDX_W'(i)) begin
                if (kind == ACC_CFG)
                    sel_word = cfg_all[i];
                else if (kind == ACC_SEM)
                    sel_word = sem_word(sem_all[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? sel_word : '0;
        end
    end

endmodule

// File: rtl/rsem_array.sv
module rsem_array
    import rsem_pkg::*;
#(
    parameter int NUM_RES = 16,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [2:0]               req_cid,
    input  logic [31:0]              req_wdata,
    output logic [31:0]              rd_data,
    output logic                     rd_valid,
    output logic [NUM_RES-1:0]       res_held,
    output logic [NUM_RES*3-1:0]     res_owner
);
    localparam int IDX_W = ADDR_W - 3;

    logic                     hit;
    acc_kind_t                kind;
    logic [IDX_W-1:0]         idx;
    word_t      [NUM_RES-1:0] cfg_all;
    sem_state_t [NUM_RES-1:0] sem_all;

    rsem_decode #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .hit       (hit),
        .kind      (kind),
        .idx       (idx)
    );

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        logic sel;
        assign sel = hit && req_write && (idx == IDX_W'(g));

        rsem_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (sel && kind == ACC_CFG),
            .sem_we   (sel && kind == ACC_SEM),
            .wdata    (req_wdata),
            .cid      (req_cid),
            .cfg_word (cfg_all[g]),
            .state    (sem_all[g])
        );

        assign res_held[g]          = sem_all[g].held;
        assign res_owner[3*g +: 3]  = sem_all[g].owner;
    end

    rsem_readmux #(.NUM_RES(NUM_RES), .IDX_W(IDX_W)) u_rdmux (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (req_valid && !req_write),
        .kind     (kind),
        .idx      (idx),
        .cfg_all  (cfg_all),
        .sem_all  (sem_all),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assert_rd_timing_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rd_valid == $past(req_valid && !req_write)));

    assert_one_change_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(res_held ^ $past(res_held)) <= 1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (res_held == '0 && res_owner == '0 && !rd_valid));

endmodule

// File: tb/test_rsem_array.sv
module test_rsem_array;
    localparam int CLK_PERIOD = 10;
    localparam int NRES  = 4;
    localparam int AW    = 6;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid;
    logic            req_write;
    logic [AW-1:0]   req_addr;
    logic [2:0]      req_cid;
    logic [31:0]     req_wdata;
    logic [31:0]     rd_data;
    logic            rd_valid;
    logic [NRES-1:0] res_held;
    logic [NRES*3-1:0] res_owner;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic        held_m [NRES];
    logic [2:0]  own_m  [NRES];
    logic [31:0] cfg_m  [NRES];

    rsem_array #(.NUM_RES(NRES), .ADDR_W(AW)) i_rsem_array (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_cid(req_cid), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .res_held(res_held), .res_owner(res_owner)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [2:0] id, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_cid = id; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R9 no rd_valid after write", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_cid = 3'd0; req_wdata = '0;
        @(negedge clk);
        req_valid = 0;
        chk("R9 rd_valid", {31'd0, rd_valid}, 32'd1);
        chk(tag, rd_data, exp);
    endtask

    function automatic logic [31:0] exp_sem(input int r);
        return {25'd0, own_m[r], 3'd0, held_m[r]};
    endfunction

    task automatic check_exports(input int target, input string tag);
        for (int r = 0; r < NRES; r++) begin
            if (r == target) begin
                chk({tag, " held"},  {31'd0, res_held[r]}, {31'd0, held_m[r]});
                chk({tag, " owner"}, {29'd0, res_owner[3*r +: 3]}, {29'd0, own_m[r]});
            end else begin
                chk("R11 other held",  {31'd0, res_held[r]}, {31'd0, held_m[r]});
                chk("R11 other owner", {29'd0, res_owner[3*r +: 3]}, {29'd0, own_m[r]});
            end
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < NRES; r++) begin
            held_m[r] = 0; own_m[r] = 0; cfg_m[r] = 0;
        end
    endtask

    task automatic sem_write(input int r, input logic [2:0] id, input logic [31:0] d);
        string tag;
        logic flt, sem, wl;
        flt = cfg_m[r][0];
        sem = cfg_m[r][1];
        wl  = cfg_m[r][16 + id];
        if (!d[0])                 tag = "R7 zero write";
        else if (!(flt && sem))    tag = "R5 mode gated";
        else if (!wl)              tag = "R6 whitelist gated";
        else if (!held_m[r]) begin tag = "R2 claim"; held_m[r] = 1; own_m[r] = id; end
        else if (own_m[r] == id) begin tag = "R3 release"; held_m[r] = 0; own_m[r] = 0; end
        else                       tag = "R4 foreign write";
        bus_write(AW'(8*r + 4), id, d);
        check_exports(r, {tag, " R10"});
        bus_read(AW'(8*r + 4), {tag, " readback"}, exp_sem(r));
    endtask

    task automatic cfg_write(input int r, input logic [31:0] d);
        cfg_m[r] = d;
        bus_write(AW'(8*r), 3'd5, d);
        bus_read(AW'(8*r), "R8 cfg readback", d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        check_exports(-1, "R1");
        for (int r = 0; r < NRES; r++) begin
            bus_read(AW'(8*r + 4), "R1 sem after reset", 32'd0);
            bus_read(AW'(8*r),     "R1 cfg after reset", 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] wls [3];
        wls[0] = 8'hFF; wls[1] = 8'h5A; wls[2] = 8'h81;
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_cid = '0; req_wdata = '0;
        do_reset();

        for (int r = 0; r < NRES; r++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int w = 0; w < 3; w++) begin
                    logic [7:0] wl;
                    wl = wls[w] ^ 8'(r * 17);
                    cfg_write(r, {8'hC3, wl, 8'h3C, 6'h2A, mode[1], mode[0]});
                    for (int pass = 0; pass < 2; pass++)
                        for (int id = 0; id < 8; id++)
                            sem_write(r, 3'(id), 32'h0000_0001 | (32'(pass) << 8));
                    for (int id = 0; id < 8; id++)
                        sem_write(r, 3'(id), 32'hFFFF_FFFE);
                end
            end
        end

        // open every resource, then claim from distinct owners and check independence
        for (int r = 0; r < NRES; r++)
            cfg_write(r, 32'h00FF_0003);
        for (int r = 0; r < NRES; r++) begin
            if (held_m[r]) sem_write(r, own_m[r], 32'd1);
            sem_write(r, 3'(r + 3), 32'd1);
        end
        for (int r = 0; r < NRES; r++)
            sem_write(r, 3'(r + 4), 32'd1);

        // misaligned and out-of-range accesses
        bus_write(AW'(8*1 + 5), 3'd4, 32'd1);
        check_exports(1, "R8 misaligned write");
        bus_read(AW'(8*1 + 6), "R8 misaligned read", 32'd0);
        for (int r = NRES; r < 8; r++) begin
            bus_write(AW'(8*r + 4), 3'd1, 32'd1);
            bus_write(AW'(8*r), 3'd1, 32'hFFFF_FFFF);
            check_exports(-1, "R8 out of range write");
            bus_read(AW'(8*r + 4), "R8 out of range sem read", 32'd0);
            bus_read(AW'(8*r),     "R8 out of range cfg read", 32'd0);
        end
        for (int r = 0; r < NRES; r++)
            bus_read(AW'(8*r), "R8 cfg intact", cfg_m[r]);

        // idle cycle: rd_valid low
        @(negedge clk);
        chk("R9 idle rd_valid", {31'd0, rd_valid}, 32'd0);

        do_reset();
        summary();
    end

endmodule